// File: doc/BRIEF.md
# Multi-Lane Bit Window Refill Unit

This block keeps the input bit windows of a group of parallel decode lanes. Each lane reads its own sub-stream, but all sub-streams are woven into one shared stream of aligned 32-bit words. A lane's words are taken in the order the lanes ask for them. The unit holds, for every lane, a 64-bit window and a count of the valid bits at its low end. A decoder reads a lane's window, finds the next code in the low bits and tells the unit how many bits that code used.

The decoder starts a round with a one-cycle pulse. It supplies a per-lane hold mask and the per-lane consumed bit counts with that pulse. The unit marks each active lane that holds fewer than 32 valid bits. It fetches one word for each marked lane through a request/acknowledge memory port. Fetches go in ascending lane order from consecutive word addresses, and each word is placed just above the lane's existing bits. The unit then advances the shared word pointer past the words it fetched. Last, it drops the consumed bits from every active lane. A one-cycle done pulse reports that the windows show the new state. At reset every lane is empty, so the first round reads words 0 to 31, one per lane. A valid stream therefore holds at least 128 bytes.

Top module: `lane_bit_refill`

## Requirements
- R1: After reset every lane window is 0, every valid count is 0, `busy`, `mem_req` and `round_done` are low, and the shared word pointer is 0.
- R2: In a round, a lane fetches a word only if it is not held and its valid count is below 32. A round in which no lane qualifies issues no memory request.
- R3: Fetches go out one at a time in ascending lane order. Each fetching lane receives exactly one word per round. The word address of a fetching lane is the shared pointer plus the number of fetching lanes with a lower lane number.
- R4: A fetched word is ORed into the lane window shifted left by the lane's valid count, and the valid count grows by 32.
- R5: When the fetches are done, the shared pointer advances by the number of lanes that fetched. The next round's first address continues from there.
- R6: After the fetches, each non-held lane shifts its window right by its consumed count and lowers its valid count by the same amount. The consumed count is taken from `consume_bits` (7 bits per lane, lane n in bits [7n+6:7n]). A consumed count larger than the valid count after refill is clamped to the valid count.
- R7: A lane whose `lane_hold` bit is 1 at the round start neither fetches nor consumes, and its window and count stay unchanged.
- R8: The first round after reset fetches words 0 to 31, one for each lane in lane order.
- R9: `mem_req` and `mem_addr` stay stable until `mem_ack`. `round_done` is a one-cycle pulse, raised only after every fetch of the round has been acknowledged, in the first cycle in which the windows show the round's result.
- R10: A `round_start` pulse that arrives while `busy` is high is ignored, together with the hold mask and consumed counts that come with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| round_start | input | 1 | Starts a round when the unit is idle |
| lane_hold | input | 32 | Per-lane hold mask for the round, sampled with `round_start` |
| consume_bits | input | 224 | Per-lane consumed bit count (7 bits each), sampled with `round_start` |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 16 | Word address of the request |
| mem_ack | input | 1 | Read acknowledge, with data valid in the same cycle |
| mem_rdata | input | 32 | Read data word |
| lane_window | output | 2048 | Per-lane 64-bit windows, lane n in bits [64n+63:64n] |
| lane_count | output | 224 | Per-lane valid bit count (7 bits each) |
| busy | output | 1 | A round is in progress |
| round_done | output | 1 | One-cycle pulse when a round's result is visible |

## Verification
A wrong pointer or wrong prefix offset shows up at once on `mem_addr`, at the first fetch of the round where it goes wrong. A bench that knows the expected address sequence can therefore catch it before any data is merged. A wrong append position or a wrong clamp leaves a lane's window or count different from the model at the `round_done` pulse of that same round. A stuck hold bit or a lost pending bit first shows as a missing or extra memory request. It then carries on into every later round's addresses, because every following lane's word index shifts.

// File: rtl/bitrefill_pkg.sv
package bitrefill_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_APPLY = 2'd2
  } round_state_e;

endpackage

// File: rtl/bitrefill_prefix.sv
// Exclusive prefix count over a lane mask: the offset of each lane is the
// number of set mask bits below it; total is the population of the mask.
module bitrefill_prefix #(
  parameter int LANES = 32,
  localparam int OFF_W = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]       mask,
  output logic [LANES*OFF_W-1:0] offsets,
  output logic [OFF_W-1:0]       total
);

  logic [OFF_W-1:0] run [LANES+1];

  assign run[0] = '0;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_chain
      assign offsets[g*OFF_W +: OFF_W] = run[g];
      assign run[g+1] = run[g] + OFF_W'(mask[g]);
    end
  endgenerate

  assign total = run[LANES];

endmodule

// File: rtl/bitrefill_pick.sv
// Lowest-numbered set lane of a mask.
module bitrefill_pick #(
  parameter int LANES = 32,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] mask,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  always_comb begin
    idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (mask[i]) idx = IDX_W'(i);
    end
  end

  assign any = |mask;

endmodule

// File: rtl/bitrefill_lane.sv
// One lane's bit window: append a word above the valid bits, or drop
// consumed bits from the bottom (clamped to the valid count).
module bitrefill_lane #(
  parameter int WORD_W = 32,
  localparam int BUF_W = 2 * WORD_W,
  localparam int CNT_W = $clog2(BUF_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              app_en,
  input  logic [WORD_W-1:0] app_word,
  input  logic              con_en,
  input  logic [CNT_W-1:0]  con_bits,
  output logic [BUF_W-1:0]  window,
  output logic [CNT_W-1:0]  count,
  output logic              need_fill
);

  logic [BUF_W-1:0] win_q, win_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] take;
  logic             upd_en;

  assign take   = (con_bits > cnt_q) ? cnt_q : con_bits;
  assign upd_en = app_en | con_en;

  always_comb begin
    win_d = win_q;
    cnt_d = cnt_q;
    if (app_en) begin
      win_d = win_q | (BUF_W'(app_word) << cnt_q);
      cnt_d = cnt_q + CNT_W'(WORD_W);
    end else if (con_en) begin
      win_d = win_q >> take;
      cnt_d = cnt_q - take;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      cnt_q <= '0;
    end else if (upd_en) begin
      win_q <= win_d;
      cnt_q <= cnt_d;
    end
  end

  assign window    = win_q;
  assign count     = cnt_q;
  assign need_fill = cnt_q < CNT_W'(WORD_W);

  // R4: the valid count never passes the window width
  p_count_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(BUF_W));

  // R2: a word is only appended to a lane that is short of bits
  p_append_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    app_en |-> (cnt_q < CNT_W'(WORD_W)));

  // R4: an append raises the count by exactly one word
  p_append_grow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    app_en |=> (cnt_q == $past(cnt_q) + CNT_W'(WORD_W)));

  // R6: a consume never raises the count
  p_consume_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (con_en && !app_en) |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/lane_bit_refill.sv
module lane_bit_refill
  import bitrefill_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 16,
  localparam int BUF_W = 2 * WORD_W,
  localparam int CNT_W = $clog2(BUF_W + 1),
  localparam int IDX_W = $clog2(LANES),
  localparam int OFF_W = $clog2(LANES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   round_start,
  input  logic [LANES-1:0]       lane_hold,
  input  logic [LANES*CNT_W-1:0] consume_bits,
  output logic                   mem_req,
  output logic [ADDR_W-1:0]      mem_addr,
  input  logic                   mem_ack,
  input  logic [WORD_W-1:0]      mem_rdata,
  output logic [LANES*BUF_W-1:0] lane_window,
  output logic [LANES*CNT_W-1:0] lane_count,
  output logic                   busy,
  output logic                   round_done
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  round_state_e           state_q, state_d;
  logic [LANES-1:0]       hold_q, want_q, want_d, pend_q, pend_d;
  logic [LANES*CNT_W-1:0] cons_q;
  logic [ADDR_W-1:0]      ptr_q, ptr_d;
  logic                   done_q, done_d;
  logic                   load_en, ptr_en;

  logic [LANES-1:0]       need_fill;
  logic [LANES*OFF_W-1:0] offsets;
  logic [OFF_W-1:0]       fetch_total;
  logic [IDX_W-1:0]       pick_idx;
  logic                   pick_any;
  logic                   fetch_take;

  bitrefill_prefix #(.LANES(LANES)) i_prefix (
    .mask    (want_q),
    .offsets (offsets),
    .total   (fetch_total)
  );

  bitrefill_pick #(.LANES(LANES)) i_pick (
    .mask (pend_q),
    .idx  (pick_idx),
    .any  (pick_any)
  );

  assign mem_req    = (state_q == ST_FETCH) && pick_any;
  assign mem_addr   = ptr_q + ADDR_W'(offsets[pick_idx*OFF_W +: OFF_W]);
  assign fetch_take = mem_req && mem_ack;

  // next-state process
  always_comb begin
    state_d = state_q;
    want_d  = ~lane_hold & need_fill;
    pend_d  = pend_q;
    ptr_d   = ptr_q + ADDR_W'(fetch_total);
    done_d  = 1'b0;
    load_en = 1'b0;
    ptr_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (round_start) begin
          load_en = 1'b1;
          pend_d  = want_d;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (fetch_take) begin
          pend_d = pend_q & ~(LANES'(1) << pick_idx);
        end
        if (!pick_any) state_d = ST_APPLY;
      end
      ST_APPLY: begin
        ptr_en  = 1'b1;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
      want_q  <= '0;
      cons_q  <= '0;
      pend_q  <= '0;
      ptr_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      done_q  <= done_d;
      if (load_en) begin
        hold_q <= lane_hold;
        want_q <= want_d;
        cons_q <= consume_bits;
      end
      if (ptr_en) ptr_q <= ptr_d;
    end
  end

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      logic app_en, con_en;
      assign app_en = fetch_take && (pick_idx == IDX_W'(g));
      assign con_en = (state_q == ST_APPLY) && !hold_q[g];

      bitrefill_lane #(.WORD_W(WORD_W)) i_lane (
        .clk       (clk),
        .rst_n     (rst_n_i),
        .app_en    (app_en),
        .app_word  (mem_rdata),
        .con_en    (con_en),
        .con_bits  (cons_q[g*CNT_W +: CNT_W]),
        .window    (lane_window[g*BUF_W +: BUF_W]),
        .count     (lane_count[g*CNT_W +: CNT_W]),
        .need_fill (need_fill[g])
      );

      // R7: a held lane never takes a word
      p_hold_no_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
        (state_q != ST_IDLE && hold_q[g]) |-> !app_en);
    end
  endgenerate

  assign busy       = (state_q != ST_IDLE);
  assign round_done = done_q;

  // R3: consecutive fetches in a round use consecutive word addresses
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mem_req && mem_ack) |=> (!mem_req || mem_addr == $past(mem_addr) + ADDR_W'(1)));

  // R9: a pending request keeps its address until acknowledged
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R9: the done flag is a single-cycle pulse with no fetch outstanding
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    round_done |=> !round_done);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    round_done |-> (!mem_req && !busy));

  // R10: a start while busy does not restart the round
  p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n_i)
    (busy && round_start && state_q == ST_FETCH && pick_any) |=> (state_q != ST_IDLE));

endmodule

// File: tb/test_lane_bit_refill.sv
`timescale 1ns/1ps
module test_lane_bit_refill;

  localparam int LANES = 32;
  localparam int CNT_W = 7;
  localparam int BUF_W = 64;

  logic                   clk;
  logic                   rst_n;
  logic                   round_start;
  logic [LANES-1:0]       lane_hold;
  logic [LANES*CNT_W-1:0] consume_bits;
  logic                   mem_req;
  logic [15:0]            mem_addr;
  logic                   mem_ack;
  logic [31:0]            mem_rdata;
  logic [LANES*BUF_W-1:0] lane_window;
  logic [LANES*CNT_W-1:0] lane_count;
  logic                   busy;
  logic                   round_done;

  lane_bit_refill i_lane_bit_refill (
    .clk(clk), .rst_n(rst_n), .round_start(round_start), .lane_hold(lane_hold),
    .consume_bits(consume_bits), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .lane_window(lane_window),
    .lane_count(lane_count), .busy(busy), .round_done(round_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] exp_q [$];

  // reference model
  logic [63:0] m_win [LANES];
  int          m_cnt [LANES];
  logic [15:0] m_ptr;
  int          cons_v [LANES];
  int unsigned lcg = 32'h1234_5678;

  function automatic logic [31:0] mem_word(input logic [15:0] a);
    return {~a ^ 16'h3C5A, a ^ 16'hA50F};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // memory model with wait states
  initial begin
    int stall = 1;
    mem_ack   = 1'b0;
    mem_rdata = '0;
    forever begin
      @(posedge clk);
      if (!rst_n) mem_ack <= 1'b0;
      else if (mem_ack) mem_ack <= 1'b0;
      else if (mem_req) begin
        if (stall > 0) stall--;
        else begin
          mem_ack   <= 1'b1;
          mem_rdata <= mem_word(mem_addr);
          stall = int'(mem_addr % 3);
        end
      end
    end
  end

  // monitor: every accepted fetch is compared with the next expected address
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req && mem_ack) begin
        if (exp_q.size() == 0)
          check(1'b0, "R2", "fetch with no lane due, addr", 64'(mem_addr), 64'hFFFF);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(mem_addr == e, "R3", "fetch address", 64'(mem_addr), 64'(e));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  task automatic compare_lanes(input string tag);
    for (int l = 0; l < LANES; l++) begin
      check(lane_window[l*BUF_W +: BUF_W] == m_win[l], tag, $sformatf("lane %0d window", l),
            lane_window[l*BUF_W +: BUF_W], m_win[l]);
      check(int'(lane_count[l*CNT_W +: CNT_W]) == m_cnt[l], tag, $sformatf("lane %0d count", l),
            64'(lane_count[l*CNT_W +: CNT_W]), 64'(m_cnt[l]));
    end
  endtask

  // driver: predicts the round, pushes expected fetches, runs it, checks result
  task automatic run_round(input logic [LANES-1:0] hold, input bit poke, input string tag);
    int k = 0;
    int waited = 0;
    for (int l = 0; l < LANES; l++) begin
      if (!hold[l] && m_cnt[l] < 32) begin
        logic [15:0] a;
        a = m_ptr + 16'(k);
        exp_q.push_back(a);
        m_win[l] = m_win[l] | (64'(mem_word(a)) << m_cnt[l]);
        m_cnt[l] += 32;
        k++;
      end
    end
    m_ptr = m_ptr + 16'(k);
    for (int l = 0; l < LANES; l++) begin
      if (!hold[l]) begin
        int c;
        c = (cons_v[l] > m_cnt[l]) ? m_cnt[l] : cons_v[l];
        m_win[l] = m_win[l] >> c;
        m_cnt[l] -= c;
      end
    end
    @(negedge clk);
    lane_hold   = hold;
    for (int l = 0; l < LANES; l++) consume_bits[l*CNT_W +: CNT_W] = 7'(cons_v[l]);
    round_start = 1'b1;
    @(negedge clk);
    round_start = 1'b0;
    if (poke) begin
      // R10: a second start with all lanes held and nothing consumed
      check(busy == 1'b1, "R10", "busy during round", 64'(busy), 64'd1);
      lane_hold    = '1;
      consume_bits = '0;
      round_start  = 1'b1;
      @(negedge clk);
      round_start  = 1'b0;
    end
    while (!round_done && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    check(round_done == 1'b1, "R9", "round_done seen", 64'(round_done), 64'd1);
    check(exp_q.size() == 0, "R5", "fetches outstanding at done", 64'(exp_q.size()), 64'd0);
    compare_lanes(tag);
    @(negedge clk);
    check(round_done == 1'b0, "R9", "round_done width", 64'(round_done), 64'd0);
    check(busy == 1'b0, "R10", "idle after round", 64'(busy), 64'd0);
  endtask

  initial begin
    rst_n        = 1'b0;
    round_start  = 1'b0;
    lane_hold    = '0;
    consume_bits = '0;
    m_ptr        = '0;
    for (int l = 0; l < LANES; l++) begin
      m_win[l] = '0;
      m_cnt[l] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check(busy == 1'b0, "R1", "busy", 64'(busy), 64'd0);
    check(mem_req == 1'b0, "R1", "mem_req", 64'(mem_req), 64'd0);
    check(round_done == 1'b0, "R1", "round_done", 64'(round_done), 64'd0);
    compare_lanes("R1");

    // R8: first round reads words 0..31
    for (int l = 0; l < LANES; l++) cons_v[l] = l;
    run_round('0, 1'b0, "R8");

    // R4: uneven consumption, some lanes keep 32 or more bits
    for (int l = 0; l < LANES; l++) cons_v[l] = (l * 9) % 41;
    run_round('0, 1'b0, "R4");

    // R7: held lanes keep their state
    for (int l = 0; l < LANES; l++) cons_v[l] = 17;
    run_round(32'hF0F0_00FF, 1'b0, "R7");

    // R6: over-large consumption is clamped, every lane empties
    for (int l = 0; l < LANES; l++) cons_v[l] = 64;
    run_round('0, 1'b0, "R6");

    // R5: all lanes fetch from the advanced pointer, nothing consumed
    for (int l = 0; l < LANES; l++) cons_v[l] = 0;
    run_round('0, 1'b0, "R5");

    // R2: every lane has 32 bits, so no fetch at all
    run_round('0, 1'b0, "R2");

    // R10: start pulse during a busy round is ignored
    for (int l = 0; l < LANES; l++) cons_v[l] = (l % 3 == 0) ? 31 : 5;
    run_round('0, 1'b1, "R10");

    // R4: mixed pseudo-random rounds
    for (int r = 0; r < 30; r++) begin
      logic [LANES-1:0] h;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      h = lcg & {lcg[15:0], lcg[31:16]} & 32'h3333_3333;
      for (int l = 0; l < LANES; l++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        cons_v[l] = int'((lcg >> 20) % 40);
      end
      run_round(h, 1'b0, "R4");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule